// File: doc/BRIEF.md
# Privilege-Aware Address Translation Front End

This block accepts one memory access at a time (a virtual address plus an access kind: instruction fetch, data load or data store) and returns either a physical address or a fault. From a small status word it works out the privilege level that governs the access. If that level is machine mode, the address is passed straight through after the bits above the architectural register width are cleared. Otherwise the block hands the address to an external page-table walker over a valid/ready handshake, waits for the walker's answer, and builds the physical address from the returned page base and the page offset.

Every result, whether passed through or walked, is checked against a memory-size bound. A walker-reported page fault and an out-of-range address are reported as different fault codes, each tagged with the access kind. A single-cycle done pulse marks the result. No new access is taken while a walk is in flight.

Top module: `addr_xlate_front`

## Requirements
- R1: The status word is laid out as: bits [1:0] current privilege, bits [3:2] previous privilege, bit 4 modify-privilege flag, bits [7:5] translation mode (0 = bare). Privilege codes are U=0, S=1, M=3. Access kinds are fetch=0, load=1, store=2. For a fetch, the effective privilege is the current privilege, and the modify-privilege flag has no effect.
- R2: For a load or a store with the modify-privilege flag set, the effective privilege is the previous privilege. With the flag clear, it is the current privilege.
- R3: A bare translation mode forces the effective privilege to M for every access kind, overriding R1 and R2.
- R4: When the effective privilege is M, no walk is requested, and done_o is high in the cycle after acceptance. paddr_o then equals the virtual address with every bit at or above XLEN cleared.
- R5: Otherwise walk_valid_o rises in the cycle after acceptance, carrying the virtual address, the access kind and walk_super_o (high when the effective privilege is not U). These outputs stay valid and unchanged until walk_ready_i is sampled high.
- R6: After the handshake, the walker returns wrsp_valid_i with a page-aligned base. paddr_o equals that base ORed with virtual address bits [11:0], and done_o is high in the cycle after the response.
- R7: If the walker reports no page fault and paddr_o is at or above MEM_SIZE, fault_o is high and fault_code_o is 1, 2 or 3 for fetch, load or store. A result below MEM_SIZE carries code 0 and fault_o low.
- R8: A walker page fault gives fault_code_o 5, 6 or 7 for fetch, load or store, with fault_o high. It takes precedence over the bound check of R7.
- R9: req_ready_o is low from acceptance of a walked access until its response arrives. A request offered during that time is ignored and does not disturb the walk or its result.
- R10: After reset, req_ready_o is high while done_o, fault_o and walk_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_type_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| status_i | input | 8 | Privilege and translation-mode status word |
| walk_valid_o | output | 1 | Walk request valid |
| walk_ready_i | input | 1 | Walker accepts the request |
| walk_vaddr_o | output | VA_W | Address to be walked |
| walk_type_o | output | 2 | Access kind of the walk |
| walk_super_o | output | 1 | Walk is made at a privilege above U |
| wrsp_valid_i | input | 1 | Walker response valid |
| wrsp_base_i | input | VA_W | Page-aligned physical base from the walker |
| wrsp_pfault_i | input | 1 | Walker found a page fault |
| done_o | output | 1 | One-cycle result strobe |
| paddr_o | output | VA_W | Physical address result |
| fault_o | output | 1 | Result is a fault |
| fault_code_o | output | 3 | Fault code per R7 and R8, 0 when no fault |

## Verification
The assertions take for granted three things about the inputs. The access kind is never the unused code 3 while a request is offered. The walker's base has its twelve low bits clear when it responds. The walker answers only after it has accepted a request. The bench keeps within these limits by drawing access kinds from the three legal codes and forming every base from a random page number shifted up by twelve. Its walker model raises its response only after the request handshake, with random delays on both sides. Privilege fields are drawn only from U, S and M, and the translation mode is bare about a quarter of the time, so both the passthrough path and the walk path are exercised under random data.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int STAT_W    = 8;
  localparam int CUR_LSB   = 0;
  localparam int PREV_LSB  = 2;
  localparam int MPRV_BIT  = 4;
  localparam int VM_LSB    = 5;
  localparam int VM_W      = 3;
  localparam logic [VM_W-1:0] VM_BARE = '0;
  localparam int PG_OFF_W  = 12;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xlate_st_e;
endpackage

// File: rtl/xlate_priv_sel.sv
module xlate_priv_sel
  import xlate_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  input  logic [1:0]        acc_i,
  output logic [1:0]        eff_priv_o,
  output logic              machine_o
);
  always_comb begin
    eff_priv_o = status_i[CUR_LSB +: 2];
    // data accesses may borrow the previous privilege
    if (acc_i != ACC_FETCH && status_i[MPRV_BIT])
      eff_priv_o = status_i[PREV_LSB +: 2];
    if (status_i[VM_LSB +: VM_W] == VM_BARE)
      eff_priv_o = PRIV_M;
  end

  assign machine_o = (eff_priv_o == PRIV_M);
endmodule

// File: rtl/xlate_fault_chk.sv
module xlate_fault_chk #(
  parameter int              VA_W     = 64,
  parameter logic [VA_W-1:0] MEM_SIZE = 'h8000_0000
) (
  input  logic [VA_W-1:0] paddr_i,
  input  logic [1:0]      acc_i,
  input  logic            page_fault_i,
  output logic [2:0]      code_o
);
  logic [1:0] kind;

  // code = {page, kind}; kind is 1/2/3 for fetch/load/store
  assign kind = acc_i + 2'd1;

  always_comb begin
    if (page_fault_i)             code_o = {1'b1, kind};
    else if (paddr_i >= MEM_SIZE) code_o = {1'b0, kind};
    else                          code_o = 3'd0;
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_walk_i,
  input  logic walk_ready_i,
  input  logic wrsp_valid_i,
  output logic idle_o,
  output logic walk_valid_o,
  output logic rsp_take_o
);
  xlate_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_walk_i) st_d = ST_REQ;
      ST_REQ:  if (walk_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (wrsp_valid_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign walk_valid_o = (st_q == ST_REQ);
  assign rsp_take_o   = (st_q == ST_WAIT) && wrsp_valid_i;

  // R9: no second request accepted while a walk is open
  p_single_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> !(st_q == ST_IDLE && $past(st_q) == ST_REQ));

  // input assumption: response only after the walk handshake
  p_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsp_valid_i |-> st_q == ST_WAIT);
endmodule

// File: rtl/addr_xlate_front.sv
module addr_xlate_front
  import xlate_pkg::*;
#(
  parameter int              VA_W     = 64,
  parameter int              XLEN     = 32,
  parameter logic [VA_W-1:0] MEM_SIZE = 'h8000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_type_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              walk_valid_o,
  input  logic              walk_ready_i,
  output logic [VA_W-1:0]   walk_vaddr_o,
  output logic [1:0]        walk_type_o,
  output logic              walk_super_o,
  input  logic              wrsp_valid_i,
  input  logic [VA_W-1:0]   wrsp_base_i,
  input  logic              wrsp_pfault_i,
  output logic              done_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic              fault_o,
  output logic [2:0]        fault_code_o
);
  localparam int              MASK_SH = (XLEN >= VA_W) ? 0 : VA_W - XLEN;
  localparam logic [VA_W-1:0] XMASK   = {VA_W{1'b1}} >> MASK_SH;
  localparam logic [VA_W-1:0] OFFMASK = {{(VA_W-PG_OFF_W){1'b0}}, {PG_OFF_W{1'b1}}};

  logic [1:0]      eff_priv;
  logic            machine, idle, rsp_take;
  logic            accept, take_m, start_walk, finish;
  logic [VA_W-1:0] vaddr_q, paddr_q, paddr_m, paddr_w, chk_paddr;
  logic [1:0]      acc_q, chk_acc;
  logic            super_q, done_q, chk_page;
  logic [2:0]      code_q, chk_code;

  xlate_priv_sel u_priv (
    .status_i   (status_i),
    .acc_i      (req_type_i),
    .eff_priv_o (eff_priv),
    .machine_o  (machine)
  );

  xlate_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_walk_i (start_walk),
    .walk_ready_i (walk_ready_i),
    .wrsp_valid_i (wrsp_valid_i),
    .idle_o       (idle),
    .walk_valid_o (walk_valid_o),
    .rsp_take_o   (rsp_take)
  );

  assign accept     = req_valid_i && idle;
  assign take_m     = accept && machine;
  assign start_walk = accept && !machine;
  assign finish     = take_m || rsp_take;

  assign paddr_m   = req_vaddr_i & XMASK;
  assign paddr_w   = wrsp_base_i | (vaddr_q & OFFMASK);
  assign chk_paddr = rsp_take ? paddr_w : paddr_m;
  assign chk_acc   = rsp_take ? acc_q : req_type_i;
  assign chk_page  = rsp_take && wrsp_pfault_i;

  xlate_fault_chk #(.VA_W(VA_W), .MEM_SIZE(MEM_SIZE)) u_chk (
    .paddr_i      (chk_paddr),
    .acc_i        (chk_acc),
    .page_fault_i (chk_page),
    .code_o       (chk_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      acc_q   <= ACC_FETCH;
      super_q <= 1'b0;
      done_q  <= 1'b0;
      paddr_q <= '0;
      code_q  <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        vaddr_q <= req_vaddr_i;
        acc_q   <= req_type_i;
        super_q <= (eff_priv != PRIV_U);
      end
      if (finish) begin
        paddr_q <= chk_paddr;
        code_q  <= chk_code;
      end
    end
  end

  assign req_ready_o  = idle;
  assign walk_vaddr_o = vaddr_q;
  assign walk_type_o  = acc_q;
  assign walk_super_o = super_q;
  assign done_o       = done_q;
  assign paddr_o      = paddr_q;
  assign fault_o      = |code_q;
  assign fault_code_o = code_q;

  // R1: fetches ignore the modify-privilege flag
  p_fetch_priv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == ACC_FETCH && status_i[VM_LSB +: VM_W] != VM_BARE)
      |-> eff_priv == status_i[CUR_LSB +: 2]);

  // R4: machine-mode accesses never reach the walker
  p_machine_nowalk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && machine) |=> (done_o && !walk_valid_o && (paddr_o & ~XMASK) == '0));

  // R5: walk request held stable until taken
  p_walk_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_valid_o && !walk_ready_i) |=> (walk_valid_o && $stable(walk_vaddr_o)
      && $stable(walk_type_o) && $stable(walk_super_o)));

  // R7: a clean result is inside memory
  p_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> paddr_o < MEM_SIZE);

  // R8: a page-fault code always flags a fault
  p_page_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o[2]) |-> (fault_o && fault_code_o[1:0] != 2'd0));

  // R9: no acceptance while the walker is engaged
  p_ready_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_valid_o |-> !req_ready_o);

  // input assumptions
  p_legal_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> req_type_i != 2'd3);
  p_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsp_valid_i |-> (wrsp_base_i & OFFMASK) == '0);
endmodule

// File: tb/test_addr_xlate_front.sv
`timescale 1ns/1ps
module test_addr_xlate_front;
  localparam int          VA_W = 64;
  localparam int          XLEN = 32;
  localparam logic [63:0] MEM  = 64'h8000_0000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, walk_ready_i = 0, wrsp_valid_i = 0, wrsp_pfault_i = 0;
  logic [63:0] req_vaddr_i = '0, wrsp_base_i = '0;
  logic [1:0]  req_type_i = '0;
  logic [7:0]  status_i = '0;
  logic req_ready_o, walk_valid_o, walk_super_o, done_o, fault_o;
  logic [63:0] walk_vaddr_o, paddr_o;
  logic [1:0]  walk_type_o;
  logic [2:0]  fault_code_o;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  addr_xlate_front #(.VA_W(VA_W), .XLEN(XLEN), .MEM_SIZE(MEM)) i_addr_xlate_front (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
    .req_type_i(req_type_i), .status_i(status_i),
    .walk_valid_o(walk_valid_o), .walk_ready_i(walk_ready_i), .walk_vaddr_o(walk_vaddr_o),
    .walk_type_o(walk_type_o), .walk_super_o(walk_super_o),
    .wrsp_valid_i(wrsp_valid_i), .wrsp_base_i(wrsp_base_i), .wrsp_pfault_i(wrsp_pfault_i),
    .done_o(done_o), .paddr_o(paddr_o), .fault_o(fault_o), .fault_code_o(fault_code_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_priv(logic [7:0] st, logic [1:0] t);
    logic [1:0] p = st[1:0];
    if (t != 2'd0 && st[4]) p = st[3:2];
    if (st[7:5] == 3'd0) p = 2'd3;
    return p;
  endfunction

  function automatic logic [2:0] exp_code(logic [1:0] t, logic pg, logic [63:0] pa);
    if (pg) return {1'b1, t + 2'd1};
    if (pa >= MEM) return {1'b0, t + 2'd1};
    return 3'd0;
  endfunction

  function automatic logic [7:0] mk_st(logic [1:0] cur, logic [1:0] prev, logic mprv,
                                       logic [2:0] vm);
    return {vm, mprv, prev, cur};
  endfunction

  // one access end to end; poke offers a stray request during the walk
  task automatic xlate(input logic [63:0] va, input logic [1:0] t, input logic [7:0] st,
                       input logic [63:0] base, input logic pf, input int rdly,
                       input int sdly, input bit poke);
    logic [1:0]  ep = exp_priv(st, t);
    logic [63:0] pa;
    req_valid_i = 1; req_vaddr_i = va; req_type_i = t; status_i = st;
    @(posedge clk); @(negedge clk);
    req_valid_i = 0;
    if (ep == 2'd3) begin
      pa = va & 64'h0000_0000_FFFF_FFFF;
      chk("R4 done", done_o, 1);
      chk("R4 no walk", walk_valid_o, 0);
      chk("R4 paddr", paddr_o, pa);
      chk("R7 code", fault_code_o, exp_code(t, 1'b0, pa));
      chk("R7 fault", fault_o, exp_code(t, 1'b0, pa) != 0);
    end else begin
      chk("R5 walk valid", walk_valid_o, 1);
      chk("R5 vaddr", walk_vaddr_o, va);
      chk("R5 type", walk_type_o, t);
      chk("R5 super", walk_super_o, ep != 2'd0);
      chk("R9 ready low", req_ready_o, 0);
      if (poke) begin
        req_valid_i = 1; req_vaddr_i = ~va; req_type_i = 2'd0; status_i = 8'h03;
      end
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        chk("R5 hold valid", walk_valid_o, 1);
        chk(poke ? "R9 stray ignored" : "R5 hold vaddr", walk_vaddr_o, va);
      end
      req_valid_i = 0;
      walk_ready_i = 1;
      @(negedge clk);
      walk_ready_i = 0;
      chk("R5 dropped after take", walk_valid_o, 0);
      for (int i = 0; i < sdly; i++) @(negedge clk);
      wrsp_valid_i = 1; wrsp_base_i = base; wrsp_pfault_i = pf;
      @(negedge clk);
      wrsp_valid_i = 0; wrsp_pfault_i = 0;
      pa = base | (va & 64'hFFF);
      chk("R6 done", done_o, 1);
      chk("R6 paddr", paddr_o, pa);
      chk(pf ? "R8 code" : "R7 code", fault_code_o, exp_code(t, pf, pa));
      chk(pf ? "R8 fault" : "R7 fault", fault_o, exp_code(t, pf, pa) != 0);
      chk("R9 ready back", req_ready_o, 1);
    end
  endtask

  function automatic logic [1:0] rnd_priv();
    logic [1:0] p = 2'($urandom % 3);
    return (p == 2'd2) ? 2'd3 : p;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R10 ready", req_ready_o, 1);
    chk("R10 done", done_o, 0);
    chk("R10 fault", fault_o, 0);
    chk("R10 walk", walk_valid_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: fetch in S, mprv with prev=U must still walk as supervisor
    xlate(64'h1234_5ABC, 2'd0, mk_st(2'd1, 2'd0, 1, 3'd1), 64'h0004_0000, 0, 1, 0, 0);
    // R1: fetch in M with mprv prev=U stays machine
    xlate(64'hFFFF_0000_0000_1000, 2'd0, mk_st(2'd3, 2'd0, 1, 3'd2), 0, 0, 0, 0, 0);
    // R2: load in M with mprv prev=U walks as user
    xlate(64'h0000_0000_0000_7123, 2'd1, mk_st(2'd3, 2'd0, 1, 3'd1), 64'h0010_0000, 0, 2, 1, 0);
    // R2: store in U with mprv prev=S walks as supervisor
    xlate(64'h0000_0000_0000_8FFF, 2'd2, mk_st(2'd0, 2'd1, 1, 3'd1), 64'h0020_0000, 0, 0, 2, 0);
    // R3: bare mode forces passthrough for a user store
    xlate(64'hABCD_0000_0000_0042, 2'd2, mk_st(2'd0, 2'd0, 0, 3'd0), 0, 0, 0, 0, 0);
    // R4/R7: high bits masked, boundary just below and at MEM
    xlate(64'hFFFF_FFFF_7FFF_FFFF, 2'd1, mk_st(2'd3, 2'd0, 0, 3'd1), 0, 0, 0, 0, 0);
    xlate(64'h0000_0001_8000_0000, 2'd1, mk_st(2'd3, 2'd0, 0, 3'd1), 0, 0, 0, 0, 0);
    xlate(64'h0000_0000_8000_0000, 2'd0, mk_st(2'd0, 2'd0, 0, 3'd0), 0, 0, 0, 0, 0);
    // R7: walked base beyond memory, store
    xlate(64'h0000_0000_0000_3456, 2'd2, mk_st(2'd1, 2'd0, 0, 3'd1), 64'h0000_0001_0000_0000, 0, 1, 1, 0);
    // R8: page fault wins over an out-of-range base
    xlate(64'h0000_0000_0000_0010, 2'd1, mk_st(2'd0, 2'd0, 0, 3'd1), 64'h0000_0001_0000_0000, 1, 0, 0, 0);
    xlate(64'h0000_0000_0000_0020, 2'd0, mk_st(2'd1, 2'd0, 0, 3'd1), 64'h0000_0000_0000_1000, 1, 1, 0, 0);
    // R9: stray request during a walk is ignored
    xlate(64'h0000_0000_0055_5555, 2'd1, mk_st(2'd1, 2'd0, 0, 3'd1), 64'h0030_0000, 0, 3, 1, 1);

    for (int n = 0; n < 400; n++) begin
      logic [1:0]  t  = 2'($urandom % 3);
      logic [7:0]  st = mk_st(rnd_priv(), rnd_priv(), 1'($urandom), 3'($urandom % 4));
      logic [63:0] va = {$urandom, $urandom};
      logic [63:0] bs = {44'($urandom % 32'h0009_0000), 12'h0} & 64'h0000_00FF_FFFF_F000;
      xlate(va, t, st, bs, ($urandom % 5) == 0, int'($urandom % 4), int'($urandom % 4),
            ($urandom % 8) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule